// File: doc/BRIEF.md
# Compare-Swap-And-Store Unit

This block runs one compare-and-swap on a memory operand. When the swap succeeds it also stores to a second, independent memory location. A command carries four things: a control word that picks the swap width and the width of the second store, a flag for the parity of the register index, and three byte addresses. Those addresses are the swap operand, the store target and a parameter list. The command also carries a compare value of up to 128 bits. The parameter list supplies the replacement value for the swap and the data for the second store.

All memory traffic goes over one 64-bit, doubleword-aligned, big-endian port, one access at a time. The unit first reads everything it needs: the parameter list, then the old operand. It compares, and only then issues any write. When it finishes it pulses `done` and reports four results: a condition code, the old operand formatted as a register pair, a specification-exception flag and a memory-fault flag. An `ext_en` input says whether the extended width set (16-byte swap, 16-byte store) is allowed.

Top module: `cas_store_unit`

## Requirements
- R1: `ctrl[7:0]` is the swap code (0, 1, 2 select 4, 8 or 16 bytes) and `ctrl[15:8]` is the store code (0..4 select 1, 2, 4, 8 or 16 bytes). The command is invalid in these cases: with `ext_en` low, a swap code above 1 or a store code above 3; with `ext_en` high, a swap code above 2, a store code above 4, or swap code 2 with `reg_odd` high. An invalid command ends with `spec_exc`=1, `cc`=0, no memory access and no change to the returned values.
- R2: The swap address must be a multiple of the swap size and the store address a multiple of the store size. If either is not, the command ends as in R1 with `spec_exc`=1.
- R3: The parameter list base is `plist_addr` with bits 3:0 cleared. The replacement value is read from base+0, and also base+8 for the 16-byte swap. The store data is read from base+16 (first doubleword) and base+24 (second doubleword).
- R4: Once the unit has issued a write in a command, it issues no read for the rest of that command.
- R5: If the old operand equals the compare value, `cc`=0 and the replacement value is written at the swap address at the selected size. A 4-byte swap uses the top 32 bits of the doubleword at base+0, and the 16-byte swap writes the high doubleword first.
- R6: If the old operand differs from the compare value, `cc`=1 and the unit issues no write at all.
- R7: Old-value format. 4-byte swap: `old_hi` = {old word, `cmp_hi[31:0]`} and `old_lo` = `cmp_lo`. 8-byte swap: `old_hi` = old doubleword and `old_lo` = `cmp_lo`. 16-byte swap: `old_hi` = the doubleword at the swap address and `old_lo` = the doubleword 8 bytes above it. Compare is against `cmp_hi[31:0]`, `cmp_hi`, or {`cmp_hi`,`cmp_lo`} respectively.
- R8: The second store is written only when `cc`=0. For sizes below 8 bytes it takes the most significant bytes of the first store-data doubleword. The 8-byte store writes that whole doubleword. The 16-byte store writes the first doubleword at the store address and the second at +8.
- R9: If `mem_fault` is high with `mem_ack` on any read, the command ends with `fault_exc`=1, `cc`=0, no write, and `old_hi`/`old_lo` equal to `cmp_hi`/`cmp_lo`.
- R10: Memory port rules. `mem_addr` bits 2:0 are always 0. The byte at offset k of the doubleword sits on `mem_wdata`/`mem_rdata` bits [63-8k:56-8k], and `mem_wstrb[k]` enables it. `mem_req` holds with a stable address and direction until `mem_ack`.
- R11: `done` is a one-cycle pulse, and the results are valid in that cycle. `busy` is high from the cycle after `start` until `done`. `start` is ignored while `busy` is high. After reset, `busy`, `done`, `mem_req`, `cc`, `spec_exc` and `fault_exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| ctrl | input | 16 | Swap code [7:0], store code [15:8] |
| reg_odd | input | 1 | Register index is odd |
| ext_en | input | 1 | Extended widths allowed |
| swap_addr | input | AW | Swap operand byte address |
| store_addr | input | AW | Second store byte address |
| plist_addr | input | AW | Parameter list byte address |
| cmp_hi | input | 64 | Compare value, high / only register |
| cmp_lo | input | 64 | Compare value, low register of pair |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| cc | output | 2 | Condition code: 0 swapped, 1 mismatch |
| old_hi | output | 64 | Returned register (high) |
| old_lo | output | 64 | Returned register (low) |
| spec_exc | output | 1 | Specification exception |
| fault_exc | output | 1 | Memory fault during loads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Doubleword-aligned address |
| mem_wdata | output | 64 | Write data, big-endian |
| mem_wstrb | output | 8 | Byte enables, bit k = offset k |
| mem_rdata | input | 64 | Read data, big-endian |
| mem_ack | input | 1 | Access complete |
| mem_fault | input | 1 | Read faulted, valid with mem_ack |

## Verification
Commands are drawn at random over every swap and store code, including the invalid ones, with both settings of `ext_en` and `reg_odd`. Compare values are forced to match the memory in half the cases. This separates the swap path from the mismatch path, and the accept/reject decode from alignment rejection. Parameter-list addresses with their low bits set test that the base is cleared. Overlapping swap, store and list regions show whether every read really happens before any write. Directed cases check four more things: the word lane picked by bit 2 of the swap address, odd-byte placement of narrow stores, a fault on the first and on the last read, and a second `start` arriving while busy.

// File: rtl/cas_store_unit.sv
`timescale 1ns/1ps
module cas_store_unit #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   ctrl,
  input  logic          reg_odd,
  input  logic          ext_en,
  input  logic [AW-1:0] swap_addr,
  input  logic [AW-1:0] store_addr,
  input  logic [AW-1:0] plist_addr,
  input  logic [63:0]   cmp_hi,
  input  logic [63:0]   cmp_lo,
  output logic          busy,
  output logic          done,
  output logic [1:0]    cc,
  output logic [63:0]   old_hi,
  output logic [63:0]   old_lo,
  output logic          spec_exc,
  output logic          fault_exc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    mem_wstrb,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_fault
);
  typedef enum logic [3:0] {
    S_IDLE, S_LSVH, S_LSVL, S_LNVH, S_LNVL, S_LOVH, S_LOVL,
    S_CMP, S_WSWH, S_WSWL, S_WSTH, S_WSTL, S_DONE
  } st_t;

  st_t st;
  logic [1:0]    fc_q;
  logic [2:0]    sc_q;
  logic [AW-1:0] a1_q, a2_q, pb_q;
  logic [63:0]   chq, clq, svh, svl, nvh, nvl, ovh, ovl;
  logic [1:0]    cc_q;
  logic          spec_q, fault_q;

  logic [7:0] fc_in, sc_in;
  logic       bad_code, spec_in, hit;
  logic [3:0] a1m;
  logic [4:0] a2m;
  logic [31:0] word_sel;
  logic [7:0] smask;
  logic [AW-1:0] a1dw, a2dw;

  assign fc_in    = ctrl[7:0];
  assign sc_in    = ctrl[15:8];
  assign bad_code = ext_en ? (fc_in > 8'd2 || sc_in > 8'd4 || (fc_in == 8'd2 && reg_odd))
                           : (fc_in > 8'd1 || sc_in > 8'd3);
  assign a1m      = (fc_in == 8'd0) ? 4'h3 : (fc_in == 8'd1) ? 4'h7 : 4'hF;
  assign a2m      = (5'd1 << sc_in[2:0]) - 5'd1;
  assign spec_in  = bad_code | (|(swap_addr[3:0] & a1m)) | (|(store_addr[3:0] & a2m[3:0]));

  assign hit = (fc_q == 2'd0) ? (ovh[63:32] == chq[31:0]) :
               (fc_q == 2'd1) ? (ovh == chq) : (ovh == chq && ovl == clq);

  assign word_sel = a1_q[2] ? mem_rdata[31:0] : mem_rdata[63:32];
  assign a1dw     = a1_q & ~AW'(7);
  assign a2dw     = a2_q & ~AW'(7);

  always_comb begin
    case (sc_q)
      3'd0:    smask = 8'h01;
      3'd1:    smask = 8'h03;
      3'd2:    smask = 8'h0F;
      default: smask = 8'hFF;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign cc        = cc_q;
  assign old_hi    = ovh;
  assign old_lo    = ovl;
  assign spec_exc  = spec_q;
  assign fault_exc = fault_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (st)
      S_LSVH: begin mem_req = 1'b1; mem_addr = pb_q + AW'(16); end
      S_LSVL: begin mem_req = 1'b1; mem_addr = pb_q + AW'(24); end
      S_LNVH: begin mem_req = 1'b1; mem_addr = pb_q; end
      S_LNVL: begin mem_req = 1'b1; mem_addr = pb_q + AW'(8); end
      S_LOVH: begin mem_req = 1'b1; mem_addr = a1dw; end
      S_LOVL: begin mem_req = 1'b1; mem_addr = a1dw + AW'(8); end
      S_WSWH: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a1dw;
        if (fc_q == 2'd0) begin
          mem_wdata = a1_q[2] ? {32'h0, nvh[63:32]} : {nvh[63:32], 32'h0};
          mem_wstrb = a1_q[2] ? 8'hF0 : 8'h0F;
        end else begin
          mem_wdata = nvh;
          mem_wstrb = 8'hFF;
        end
      end
      S_WSWL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a1dw + AW'(8);
        mem_wdata = nvl; mem_wstrb = 8'hFF;
      end
      S_WSTH: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a2dw;
        mem_wdata = svh >> {a2_q[2:0], 3'b000};
        mem_wstrb = smask << a2_q[2:0];
      end
      S_WSTL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a2dw + AW'(8);
        mem_wdata = svl; mem_wstrb = 8'hFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fc_q    <= '0;
      sc_q    <= '0;
      a1_q    <= '0;
      a2_q    <= '0;
      pb_q    <= '0;
      chq     <= '0;
      clq     <= '0;
      svh     <= '0;
      svl     <= '0;
      nvh     <= '0;
      nvl     <= '0;
      ovh     <= '0;
      ovl     <= '0;
      cc_q    <= '0;
      spec_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          fc_q    <= fc_in[1:0];
          sc_q    <= sc_in[2:0];
          a1_q    <= swap_addr;
          a2_q    <= store_addr;
          pb_q    <= plist_addr & ~AW'(15);
          chq     <= cmp_hi;
          clq     <= cmp_lo;
          ovh     <= cmp_hi;
          ovl     <= cmp_lo;
          cc_q    <= 2'd0;
          spec_q  <= spec_in;
          fault_q <= 1'b0;
          st      <= spec_in ? S_DONE : S_LSVH;
        end
        S_LSVH, S_LSVL, S_LNVH, S_LNVL, S_LOVH, S_LOVL: if (mem_ack) begin
          if (mem_fault) begin
            fault_q <= 1'b1;
            ovh     <= chq;
            ovl     <= clq;
            st      <= S_DONE;
          end else begin
            case (st)
              S_LSVH: begin svh <= mem_rdata; st <= S_LSVL; end
              S_LSVL: begin svl <= mem_rdata; st <= S_LNVH; end
              S_LNVH: begin nvh <= mem_rdata; st <= (fc_q == 2'd2) ? S_LNVL : S_LOVH; end
              S_LNVL: begin nvl <= mem_rdata; st <= S_LOVH; end
              S_LOVH: begin
                ovh <= (fc_q == 2'd0) ? {word_sel, chq[31:0]} : mem_rdata;
                st  <= (fc_q == 2'd2) ? S_LOVL : S_CMP;
              end
              default: begin ovl <= mem_rdata; st <= S_CMP; end
            endcase
          end
        end
        S_CMP: begin
          cc_q <= hit ? 2'd0 : 2'd1;
          st   <= hit ? S_WSWH : S_DONE;
        end
        S_WSWH: if (mem_ack) st <= (fc_q == 2'd2) ? S_WSWL : S_WSTH;
        S_WSWL: if (mem_ack) st <= S_WSTH;
        S_WSTH: if (mem_ack) st <= (sc_q == 3'd4) ? S_WSTL : S_DONE;
        S_WSTL: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cas_store_unit_chk.sv
`timescale 1ns/1ps
module cas_store_unit_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    cc,
  input logic          spec_exc,
  input logic          fault_exc,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wstrb,
  input logic          mem_ack
);
  logic wrote, touched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrote   <= 1'b0;
      touched <= 1'b0;
    end else if (start && !busy) begin
      wrote   <= 1'b0;
      touched <= 1'b0;
    end else if (mem_req && mem_ack) begin
      touched <= 1'b1;
      if (mem_we) wrote <= 1'b1;
    end
  end

  p_spec_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && spec_exc |-> !touched);
  p_loads_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && wrote |-> mem_we);
  p_hit_wrote_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !spec_exc && !fault_exc && cc == 2'd0 |-> wrote);
  p_miss_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && cc == 2'd1 |-> !wrote);
  p_fault_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_exc |-> !wrote);
  p_dw_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wstrb != 8'h00);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind cas_store_unit cas_store_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/cas_store_unit_test.sv
`timescale 1ns/1ps
module cas_store_unit_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, reg_odd, ext_en;
  logic [15:0] ctrl;
  logic [63:0] swap_addr, store_addr, plist_addr, cmp_hi, cmp_lo;
  logic        busy, done, spec_exc, fault_exc, mem_req, mem_we;
  logic [1:0]  cc;
  logic [63:0] old_hi, old_lo, mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  mem_wstrb;
  logic        mem_ack, mem_fault;

  cas_store_unit #(.AW(64)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .reg_odd(reg_odd),
    .ext_en(ext_en), .swap_addr(swap_addr), .store_addr(store_addr),
    .plist_addr(plist_addr), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .busy(busy),
    .done(done), .cc(cc), .old_hi(old_hi), .old_lo(old_lo), .spec_exc(spec_exc),
    .fault_exc(fault_exc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_fault(mem_fault));

  logic [7:0] mem  [0:511];
  logic [7:0] refm [0:511];
  int checks = 0, errors = 0;
  int lat = 0, loads = 0, fault_at = -1, order_err = 0;
  bit wrote_seen = 0, hung = 0;

  // memory responder: variable latency, big-endian byte lanes
  initial begin
    mem_ack = 1'b0; mem_fault = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_fault = 1'b0;
      end else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          lat = int'($urandom % 3);
          if (mem_we) begin
            wrote_seen = 1;
            for (int k = 0; k < 8; k++)
              if (mem_wstrb[k]) mem[int'((mem_addr + 64'(k)) & 64'h1FF)] = mem_wdata[63-8*k -: 8];
          end else begin
            if (wrote_seen) order_err++;
            for (int k = 0; k < 8; k++)
              mem_rdata[63-8*k -: 8] = mem[int'((mem_addr + 64'(k)) & 64'h1FF)];
            mem_fault = (loads == fault_at);
            loads++;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  function automatic logic [63:0] mrd64(input logic [63:0] a);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[63-8*k -: 8] = mem[int'((a + 64'(k)) & 64'h1FF)];
    return v;
  endfunction

  function automatic logic [63:0] rrd64(input logic [63:0] a);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[63-8*k -: 8] = refm[int'((a + 64'(k)) & 64'h1FF)];
    return v;
  endfunction

  task automatic rwr(input logic [63:0] a, input logic [127:0] v, input int n);
    for (int k = 0; k < n; k++) refm[int'((a + 64'(k)) & 64'h1FF)] = v[127-8*k -: 8];
  endtask

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ref_op(input logic [15:0] c, input logic odd, input logic ext,
                        input logic [63:0] a1, input logic [63:0] a2, input logic [63:0] pl,
                        input logic [63:0] ch, input logic [63:0] cl, input int fat,
                        output logic [1:0] ecc, output logic [63:0] eoh, output logic [63:0] eol,
                        output logic espec, output logic efault);
    int fc, sc, nld;
    logic [63:0] plb, svh, svl, nvh, nvl, o1, o2;
    logic hit;
    fc = int'(c[7:0]); sc = int'(c[15:8]);
    ecc = 2'd0; eoh = ch; eol = cl; efault = 1'b0;
    espec = ext ? (fc > 2 || sc > 4 || (fc == 2 && odd)) : (fc > 1 || sc > 3);
    if (!espec) espec = ((a1 % (64'd4 << fc)) != 0) || ((a2 % (64'd1 << sc)) != 0);
    if (espec) return;
    nld = (fc == 2) ? 6 : 4;
    if (fat >= 0 && fat < nld) begin efault = 1'b1; return; end
    plb = pl & ~64'hF;
    svh = rrd64(plb + 16); svl = rrd64(plb + 24);
    nvh = rrd64(plb);      nvl = rrd64(plb + 8);
    o1 = rrd64(a1);        o2 = rrd64(a1 + 8);
    if (fc == 0) begin eoh = {o1[63:32], ch[31:0]}; hit = (o1[63:32] == ch[31:0]); end
    else if (fc == 1) begin eoh = o1; hit = (o1 == ch); end
    else begin eoh = o1; eol = o2; hit = (o1 == ch) && (o2 == cl); end
    ecc = hit ? 2'd0 : 2'd1;
    if (hit) begin
      rwr(a1, {nvh, nvl}, 4 << fc);
      rwr(a2, {svh, svl}, 1 << sc);
    end
  endtask

  task automatic run_op(input logic [15:0] c, input logic odd, input logic ext,
                        input logic [63:0] a1, input logic [63:0] a2, input logic [63:0] pl,
                        input logic [63:0] ch, input logic [63:0] cl, input int fat, input bit poke);
    logic [1:0] ecc; logic [63:0] eoh, eol; logic espec, efault;
    int n, bad;
    if (hung) return;
    for (int i = 0; i < 512; i++) refm[i] = mem[i];
    ref_op(c, odd, ext, a1, a2, pl, ch, cl, fat, ecc, eoh, eol, espec, efault);
    @(negedge clk);
    ctrl = c; reg_odd = odd; ext_en = ext; swap_addr = a1; store_addr = a2;
    plist_addr = pl; cmp_hi = ch; cmp_lo = cl;
    loads = 0; fault_at = fat; wrote_seen = 0; order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke && !espec) begin
      // second command while busy must be ignored (R11)
      ctrl = 16'h0001; swap_addr = 64'h3; cmp_hi = ~ch; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 2000) break;
    end
    if (!done) begin
      errors++; hung = 1;
      $display("FAIL R11 watchdog act=no_done exp=done");
      return;
    end
    check64("R5 R6 cc", 64'(cc), 64'(ecc));
    check64("R7 old_hi", old_hi, eoh);
    check64("R7 old_lo", old_lo, eol);
    check64("R1 R2 spec_exc", 64'(spec_exc), 64'(espec));
    check64("R9 fault_exc", 64'(fault_exc), 64'(efault));
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== refm[i]) bad++;
    check64("R3 R5 R8 R10 memory image mismatches", 64'(bad), 64'd0);
    check64("R4 reads after write", 64'(order_err), 64'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R11 global watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [63:0] a1, a2, pl, ch, cl, t;
    int fc, sc, fat;
    logic ext, odd;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; start = 1'b0; ctrl = '0; reg_odd = 1'b0; ext_en = 1'b0;
    swap_addr = '0; store_addr = '0; plist_addr = '0; cmp_hi = '0; cmp_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R11 reset busy/done/mem_req", {61'd0, busy, done, mem_req}, 64'd0);
    check64("R11 reset cc/spec/fault", {60'd0, cc, spec_exc, fault_exc}, 64'd0);

    // R1 invalid codes
    run_op(16'h0002, 0, 0, 64'h100, 64'h40, 64'h0, 64'h1, 64'h2, -1, 0);
    run_op(16'h0002, 1, 1, 64'h100, 64'h40, 64'h0, 64'h1, 64'h2, -1, 0);
    run_op(16'h0400, 0, 0, 64'h100, 64'h40, 64'h0, 64'h1, 64'h2, -1, 0);
    run_op(16'h0500, 0, 1, 64'h100, 64'h40, 64'h0, 64'h1, 64'h2, -1, 0);
    // R2 misalignment
    run_op(16'h0001, 0, 0, 64'h104, 64'h40, 64'h0, 64'h1, 64'h2, -1, 0);
    run_op(16'h0200, 0, 0, 64'h100, 64'h42, 64'h0, 64'h1, 64'h2, -1, 0);
    // R5 R7 R8: 4-byte swap in upper lane, byte store at odd address, list base with low bits set (R3)
    t = mrd64(64'h0C4);
    run_op(16'h0000, 0, 0, 64'h0C4, 64'h1F3, 64'h13B, {32'hDEADBEEF, t[63:32]}, 64'h77, -1, 0);
    // 4-byte swap in lower lane, halfword store
    t = mrd64(64'h0A0);
    run_op(16'h0100, 0, 0, 64'h0A0, 64'h0E6, 64'h1C5, {32'h12345678, t[63:32]}, 64'h9, -1, 0);
    // R6 mismatch
    t = mrd64(64'h088);
    run_op(16'h0301, 0, 0, 64'h088, 64'h010, 64'h060, ~t, 64'h5, -1, 0);
    // R5 R8 16-byte swap and 16-byte store
    run_op(16'h0402, 0, 1, 64'h100, 64'h1A0, 64'h040, mrd64(64'h100), mrd64(64'h108), -1, 0);
    // R9 faults on first and on last read
    run_op(16'h0301, 0, 0, 64'h0B8, 64'h020, 64'h080, mrd64(64'h0B8), 64'h0, 0, 0);
    run_op(16'h0402, 0, 1, 64'h120, 64'h1E0, 64'h0C0, mrd64(64'h120), mrd64(64'h128), 5, 0);
    // R11 start while busy
    run_op(16'h0301, 0, 0, 64'h0F8, 64'h030, 64'h170, mrd64(64'h0F8), 64'h0, -1, 1);

    for (int it = 0; it < 300; it++) begin
      fc = int'($urandom % 4); sc = int'($urandom % 6);
      ext = ($urandom % 4) != 0; odd = 1'($urandom % 2);
      a1 = 64'($urandom % 512);
      if ($urandom % 8 != 0) a1 = a1 & ~((64'd4 << fc) - 1);
      a2 = 64'($urandom % 512);
      if ($urandom % 8 != 0) a2 = a2 & ~((64'd1 << sc) - 1);
      pl = 64'($urandom % 512);
      ch = {$urandom, $urandom}; cl = {$urandom, $urandom};
      if ($urandom % 2 == 0) begin
        t = mrd64(a1);
        if (fc == 0) ch[31:0] = t[63:32];
        else begin ch = t; cl = mrd64(a1 + 8); end
      end
      fat = ($urandom % 10 == 0) ? int'($urandom % 6) : -1;
      run_op({8'(sc), 8'(fc)}, odd, ext, a1, a2, pl, ch, cl, fat, ($urandom % 10) == 0);
    end
    finish_run();
  end
endmodule